// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a chip's 8-bit configuration registers from a serial EEPROM over a two-wire bus on which it is the master. When reset is released and the strap input selects it, the loader starts on its own. It points the EEPROM at word address zero and then reads the bytes out one after another. It hands each byte to the register file through a one-cycle write port (address, data, write strobe), register 0 first and register 120 last.

The loader makes the serial clock itself by dividing the system clock. Each bit takes four equal quarters: SCL is low for the first two and high for the last two. The master changes SDA one quarter after SCL falls and samples it at the end of the first high quarter. A 121-bit mask marks the read-only registers; their bytes are still read from the EEPROM but never written. If an address byte is not acknowledged, the loader raises an error flag, ends the transfer with a STOP and still reports completion, so the rest of the chip can carry on with its reset defaults.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: The download begins without any trigger once reset is released, and only if `loader_en_i` is high in the first cycle after reset. If it is low, SCL and SDA stay high, no register is written and `done_o` stays low.
- R2: The bus sequence is START, `{DEV_ADDR,0}` (0xA0 by default), word address 0x00, a repeated START, `{DEV_ADDR,1}` (0xA1), then 121 data bytes. Every byte travels MSB first.
- R3: Data byte k (k = 0..120) is written to register address k. There is exactly one write pulse per byte, and addresses strictly ascend.
- R4: When `ro_mask_i[k]` is 1, data byte k produces no write pulse. Other addresses are unaffected.
- R5: The master sends ACK (SDA low) after each of the first 120 data bytes and NACK (SDA released) after byte 120, then a STOP.
- R6: A NACK on any address byte sets `err_o`, leads to a STOP and sets `done_o`. No register is written.
- R7: Each SCL low phase lasts exactly two quarters (2 x QTR_CYC system clocks). SDA changes while SCL is high only to form START or STOP.
- R8: `done_o` rises after the STOP completes. `done_o` and `err_o` stay set until the next reset.
- R9: SCL and SDA are released high while idle and after the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loader_en_i | input | 1 | Strap: loader mode selected |
| ro_mask_i | input | NUM_REGS | 1 = register is read-only, skip its write |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | Serial clock (1 = released) |
| sda_o | output | 1 | SDA drive (0 = pull low, 1 = release) |
| reg_we_o | output | 1 | Register file write strobe |
| reg_addr_o | output | IDX_W | Register file write address |
| reg_data_o | output | 8 | Register file write data |
| done_o | output | 1 | Download finished (sticky) |
| err_o | output | 1 | Address byte not acknowledged (sticky) |

## Verification
The hardest condition to reach from the ports is the error path: the device address must be refused at the bit level, in the middle of a transfer that otherwise looks normal. The bench models the EEPROM directly on the SCL and SDA wires, and a knob makes it answer the device address with NACK. The bench then checks that the loader stops cleanly without writing anything. Random EEPROM contents and random read-only masks, together with the all-zero and all-one masks, exercise the write filter across the whole address range.

// File: rtl/ee_ld_pkg.sv
package ee_ld_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WR, BC_RD} bus_cmd_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_OFF, SQ_START, SQ_TX, SQ_TACK, SQ_RX, SQ_RACK, SQ_STOP, SQ_FIN
  } seq_st_e;
endpackage

// File: rtl/ee_ld_qtick.sv
module ee_ld_qtick #(
  parameter int QTR_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ee_ld_bit_eng.sv
module ee_ld_bit_eng
  import ee_ld_pkg::*;
#(
  parameter int QTR_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_valid_i,
  input  bus_cmd_e cmd_i,
  input  logic     cmd_bit_i,
  input  logic     sda_i,
  output logic     scl_o,
  output logic     sda_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     rd_bit_o
);
  logic     busy_q, done_q, scl_q, sda_q, rd_q, bit_q, tick;
  logic [1:0] q_q;
  bus_cmd_e cmd_q;

  ee_ld_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      q_q    <= '0;
      cmd_q  <= BC_STOP;
      bit_q  <= 1'b1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      rd_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid_i) begin
          busy_q <= 1'b1;
          q_q    <= 2'd0;
          cmd_q  <= cmd_i;
          bit_q  <= cmd_bit_i;
          scl_q  <= 1'b0;
        end
      end else if (tick) begin
        case (q_q)
          2'd0: begin
            q_q <= 2'd1;
            // data moves a quarter after the falling edge
            case (cmd_q)
              BC_START: sda_q <= 1'b1;
              BC_STOP:  sda_q <= 1'b0;
              BC_WR:    sda_q <= bit_q;
              default:  sda_q <= 1'b1;
            endcase
          end
          2'd1: begin
            q_q   <= 2'd2;
            scl_q <= 1'b1;
          end
          2'd2: begin
            q_q  <= 2'd3;
            rd_q <= sda_i;
            if (cmd_q == BC_START)     sda_q <= 1'b0;
            else if (cmd_q == BC_STOP) sda_q <= 1'b1;
          end
          default: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign scl_o    = scl_q;
  assign sda_o    = sda_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rd_bit_o = rd_q;

  p_sda_still_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && scl_q && $past(scl_q) &&
     (cmd_q == BC_WR || cmd_q == BC_RD)) |-> $stable(sda_q));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !cmd_valid_i) |=> ($stable(scl_q) && $stable(sda_q)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/ee_ld_seq.sv
module ee_ld_seq
  import ee_ld_pkg::*;
#(
  parameter int         NUM_REGS = 121,
  parameter int         IDX_W    = 7,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                loader_en_i,
  input  logic [NUM_REGS-1:0] ro_mask_i,
  input  logic                bit_done_i,
  input  logic                rd_bit_i,
  output logic                cmd_valid_o,
  output bus_cmd_e            cmd_o,
  output logic                cmd_bit_o,
  output logic                reg_we_o,
  output logic [IDX_W-1:0]    reg_addr_o,
  output logic [7:0]          reg_data_o,
  output logic                done_o,
  output logic                err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  seq_st_e          st_q;
  logic             wait_q, cv_q, cb_q, we_q, done_q, err_q;
  bus_cmd_e         cmd_q;
  logic [2:0]       bit_cnt_q;
  logic [1:0]       tx_sel_q;
  logic [6:0]       sh_q;
  logic [IDX_W-1:0] rx_idx_q, addr_q;
  logic [7:0]       data_q, tx_byte;

  always_comb begin
    case (tx_sel_q)
      2'd0:    tx_byte = {DEV_ADDR, 1'b0};
      2'd1:    tx_byte = 8'h00;
      default: tx_byte = {DEV_ADDR, 1'b1};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SQ_IDLE;
      wait_q    <= 1'b0;
      cv_q      <= 1'b0;
      cb_q      <= 1'b1;
      cmd_q     <= BC_STOP;
      we_q      <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      bit_cnt_q <= '0;
      tx_sel_q  <= '0;
      sh_q      <= '0;
      rx_idx_q  <= '0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      cv_q <= 1'b0;
      we_q <= 1'b0;
      case (st_q)
        SQ_IDLE: st_q <= loader_en_i ? SQ_START : SQ_OFF;
        SQ_OFF, SQ_FIN: ;
        default: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
            cv_q   <= 1'b1;
            cb_q   <= 1'b1;
            case (st_q)
              SQ_START: cmd_q <= BC_START;
              SQ_TX: begin
                cmd_q <= BC_WR;
                cb_q  <= tx_byte[3'd7 - bit_cnt_q];
              end
              SQ_RACK: begin
                cmd_q <= BC_WR;
                cb_q  <= (rx_idx_q == LAST_IDX);
              end
              SQ_STOP: cmd_q <= BC_STOP;
              default: cmd_q <= BC_RD;
            endcase
          end else if (bit_done_i) begin
            wait_q <= 1'b0;
            case (st_q)
              SQ_START: begin
                st_q      <= SQ_TX;
                bit_cnt_q <= '0;
              end
              SQ_TX: begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == 3'd7) st_q <= SQ_TACK;
              end
              SQ_TACK: begin
                if (rd_bit_i) begin
                  err_q <= 1'b1;
                  st_q  <= SQ_STOP;
                end else if (tx_sel_q == 2'd0) begin
                  tx_sel_q <= 2'd1;
                  st_q     <= SQ_TX;
                end else if (tx_sel_q == 2'd1) begin
                  tx_sel_q <= 2'd2;
                  st_q     <= SQ_START;
                end else begin
                  st_q <= SQ_RX;
                end
              end
              SQ_RX: begin
                sh_q      <= {sh_q[5:0], rd_bit_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (bit_cnt_q == 3'd7) begin
                  st_q   <= SQ_RACK;
                  we_q   <= !ro_mask_i[rx_idx_q];
                  addr_q <= rx_idx_q;
                  data_q <= {sh_q, rd_bit_i};
                end
              end
              SQ_RACK: begin
                if (rx_idx_q == LAST_IDX) st_q <= SQ_STOP;
                else begin
                  rx_idx_q <= rx_idx_q + 1'b1;
                  st_q     <= SQ_RX;
                end
              end
              SQ_STOP: begin
                st_q   <= SQ_FIN;
                done_q <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign cmd_valid_o = cv_q;
  assign cmd_o       = cmd_q;
  assign cmd_bit_o   = cb_q;
  assign reg_we_o    = we_q;
  assign reg_addr_o  = addr_q;
  assign reg_data_o  = data_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(err_q)));

  p_ro_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> !ro_mask_i[addr_q]);

  p_addr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (addr_q <= LAST_IDX));

  p_no_wr_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !we_q);

  p_quiet_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !cv_q);
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import ee_ld_pkg::*;
#(
  parameter int         SYS_CLK_MHZ   = 200,
  parameter int         SCL_PERIOD_NS = 16384,
  parameter int         NUM_REGS      = 121,
  parameter logic [6:0] DEV_ADDR      = 7'h50,
  localparam int        IDX_W         = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                loader_en_i,
  input  logic [NUM_REGS-1:0] ro_mask_i,
  input  logic                sda_i,
  output logic                scl_o,
  output logic                sda_o,
  output logic                reg_we_o,
  output logic [IDX_W-1:0]    reg_addr_o,
  output logic [7:0]          reg_data_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int QTR_RAW = (SYS_CLK_MHZ * SCL_PERIOD_NS) / 4000;
  localparam int QTR_CYC = (QTR_RAW < 1) ? 1 : QTR_RAW;

  logic     cmd_valid, cmd_bit, bit_busy, bit_done, rd_bit;
  bus_cmd_e cmd;

  ee_ld_seq #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .loader_en_i(loader_en_i),
    .ro_mask_i  (ro_mask_i),
    .bit_done_i (bit_done),
    .rd_bit_i   (rd_bit),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd),
    .cmd_bit_o  (cmd_bit),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_data_o (reg_data_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  ee_ld_bit_eng #(.QTR_CYC(QTR_CYC)) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_i      (cmd),
    .cmd_bit_i  (cmd_bit),
    .sda_i      (sda_i),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .busy_o     (bit_busy),
    .done_o     (bit_done),
    .rd_bit_o   (rd_bit)
  );

  p_cmd_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid |-> !bit_busy);
endmodule

// File: tb/tb_cfg_eeprom_loader.sv
`timescale 1ns/1ps
module tb_cfg_eeprom_loader;
  localparam int NREG = 121;
  localparam int QTR  = 4;  // 200 MHz * 80 ns / 4

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic loader_en = 1'b0;
  logic [NREG-1:0] ro_mask = '0;
  logic slv_sda;
  logic scl, sda_m, we, done, err;
  logic [6:0] waddr;
  logic [7:0] wdata;
  wire sda_bus = sda_m & slv_sda;

  always #2.5 clk = ~clk;

  cfg_eeprom_loader #(.SYS_CLK_MHZ(200), .SCL_PERIOD_NS(80), .NUM_REGS(NREG)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .loader_en_i(loader_en), .ro_mask_i(ro_mask),
    .sda_i(sda_bus), .scl_o(scl), .sda_o(sda_m), .reg_we_o(we),
    .reg_addr_o(waddr), .reg_data_o(wdata), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [0:127];
  logic nack_dev = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // EEPROM model and monitors, all on the falling clock edge
  typedef enum logic [1:0] {M_IDLE, M_DEV, M_WORD, M_READ} mph_e;
  mph_e ph;
  logic p_scl, p_sda, in_ack, m_ack;
  logic [3:0] bcnt;
  logic [7:0] sh, ptr;
  logic [7:0] tx_log [0:3];
  int n_tx, n_start, n_stop, n_mack, n_mnack, nack_ptr;
  int n_wr, order_err, last_addr, low_cnt, low_err, n_scl_low;
  logic got_wr [0:127];
  logic [7:0] got_d [0:127];

  always @(negedge clk) begin
    if (!rst_ni) begin
      ph <= M_IDLE; p_scl <= 1'b1; p_sda <= 1'b1; in_ack <= 1'b0; m_ack <= 1'b1;
      bcnt <= '0; sh <= '0; ptr <= '0; slv_sda <= 1'b1;
      n_tx <= 0; n_start <= 0; n_stop <= 0; n_mack <= 0; n_mnack <= 0; nack_ptr <= -1;
    end else begin
      p_scl <= scl;
      p_sda <= sda_bus;
      if (scl && p_scl && p_sda && !sda_bus) begin
        n_start <= n_start + 1; ph <= M_DEV; bcnt <= '0; in_ack <= 1'b0; slv_sda <= 1'b1;
      end else if (scl && p_scl && !p_sda && sda_bus) begin
        n_stop <= n_stop + 1; ph <= M_IDLE; slv_sda <= 1'b1;
      end else if (scl && !p_scl && ph != M_IDLE) begin
        if (in_ack) m_ack <= sda_bus;
        else begin sh <= {sh[6:0], sda_bus}; bcnt <= bcnt + 1'b1; end
      end else if (!scl && p_scl && ph != M_IDLE) begin
        if (in_ack) begin
          in_ack <= 1'b0; bcnt <= '0; slv_sda <= 1'b1;
          case (ph)
            M_DEV: begin
              if (nack_dev) ph <= M_IDLE;
              else if (sh[0]) begin ph <= M_READ; slv_sda <= mem[ptr[6:0]][7]; end
              else ph <= M_WORD;
            end
            M_WORD: begin ptr <= sh; ph <= M_IDLE; end
            default: begin
              if (!m_ack) begin
                n_mack <= n_mack + 1; ptr <= ptr + 1'b1;
                slv_sda <= mem[7'(ptr + 1'b1)][7];
              end else begin
                n_mnack <= n_mnack + 1; nack_ptr <= int'(ptr); ph <= M_IDLE;
              end
            end
          endcase
        end else if (bcnt == 4'd8) begin
          in_ack <= 1'b1;
          if (ph == M_READ) slv_sda <= 1'b1;
          else begin
            if (n_tx < 4) tx_log[n_tx[1:0]] <= sh;
            n_tx <= n_tx + 1;
            slv_sda <= (nack_dev && ph == M_DEV) ? 1'b1 : 1'b0;
          end
        end else if (ph == M_READ) begin
          slv_sda <= mem[ptr[6:0]][3'(4'd7 - bcnt)];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      n_wr <= 0; order_err <= 0; last_addr <= -1; low_cnt <= 0; low_err <= 0; n_scl_low <= 0;
      for (int i = 0; i < 128; i++) begin got_wr[i] <= 1'b0; got_d[i] <= '0; end
    end else begin
      if (we) begin
        n_wr <= n_wr + 1;
        if (int'(waddr) <= last_addr) order_err <= order_err + 1;
        last_addr <= int'(waddr);
        got_wr[waddr] <= 1'b1;
        got_d[waddr] <= wdata;
      end
      if (!scl) begin low_cnt <= low_cnt + 1; n_scl_low <= n_scl_low + 1; end
      else begin
        if (low_cnt != 0 && low_cnt != 2*QTR) low_err <= low_err + 1;
        low_cnt <= 0;
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    check(done == 1'b1, {tag, " watchdog/done"}, done, 1);
  endtask

  task automatic run_good(input logic [NREG-1:0] m, input string tag);
    int exp_wr = 0, bad = 0;
    loader_en = 1'b1; nack_dev = 1'b0; ro_mask = m;
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    do_reset();
    @(negedge clk);
    check(done == 0 && err == 0 && scl == 1, {tag, " R8 reset state"}, done, 0);
    wait_done(tag);
    repeat (20) @(negedge clk);
    check(err == 0, {tag, " R6 no error"}, err, 0);
    check(tx_log[0] == 8'hA0 && tx_log[1] == 8'h00 && tx_log[2] == 8'hA1 && n_tx == 3,
          {tag, " R2 address bytes"}, tx_log[0], 8'hA0);
    check(n_start == 2, {tag, " R1/R2 start count"}, n_start, 2);
    check(n_mack == NREG - 1 && n_mnack == 1 && nack_ptr == NREG - 1,
          {tag, " R5 ack pattern"}, n_mack, NREG - 1);
    check(n_stop == 1, {tag, " R5 stop"}, n_stop, 1);
    for (int i = 0; i < NREG; i++) begin
      if (!m[i]) exp_wr++;
      if (got_wr[i] != !m[i] || (!m[i] && got_d[i] != mem[i])) bad++;
    end
    check(bad == 0, {tag, " R3/R4 register contents"}, bad, 0);
    check(n_wr == exp_wr, {tag, " R4 write count"}, n_wr, exp_wr);
    check(order_err == 0, {tag, " R3 ascending"}, order_err, 0);
    check(low_err == 0, {tag, " R7 scl low width"}, low_err, 0);
    check(scl == 1 && sda_bus == 1, {tag, " R9 released"}, {scl, sda_bus}, 3);
    repeat (200) @(negedge clk);
    check(done == 1 && err == 0 && n_wr == exp_wr, {tag, " R8 sticky"}, done, 1);
  endtask

  initial begin : main
    logic [NREG-1:0] m;
    void'($urandom(32'h5eed_0042));

    // R1: loader not selected
    loader_en = 1'b0;
    do_reset();
    repeat (3000) @(negedge clk);
    check(n_scl_low == 0 && n_start == 0, "R1 no bus activity", n_scl_low, 0);
    check(n_wr == 0 && done == 0, "R1 no writes, no done", n_wr, 0);

    for (int i = 0; i < NREG; i++) m[i] = 1'($urandom);
    run_good(m, "rand mask");
    run_good('0, "zero mask");
    run_good('1, "full mask");
    for (int i = 0; i < NREG; i++) m[i] = ($urandom % 4) == 0;
    m[0] = 1'b1; m[NREG-1] = 1'b1;
    run_good(m, "edge mask");

    // R6: device address refused
    loader_en = 1'b1; nack_dev = 1'b1; ro_mask = '0;
    do_reset();
    wait_done("nack");
    repeat (20) @(negedge clk);
    check(err == 1, "R6 error flag", err, 1);
    check(n_wr == 0, "R6 no writes", n_wr, 0);
    check(n_start == 1 && n_stop == 1, "R6 stop after nack", n_stop, 1);
    check(scl == 1 && sda_bus == 1, "R9 released after error", {scl, sda_bus}, 3);
    repeat (100) @(negedge clk);
    check(done == 1 && err == 1, "R8 sticky error", err, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule